// File: doc/BRIEF.md
# HDLC Transmit Framer

This block turns a stream of payload bytes into a continuous stream of 8-bit line octets carrying HDLC frames. A frame on the line is an opening flag (0x7E), the payload bits, a 16-bit frame check sequence, and a closing flag. Zero bits are stuffed after any five consecutive ones in the payload and check sequence, so neither field can look like a flag. Frame fields are packed into octets at whatever bit position they reach. Nothing keeps them aligned to octet boundaries.

Between frames the line carries either back-to-back flags (bearer style) or all-ones idle (signalling style), chosen by a static configuration input. Two more static options shape each octet. One reverses the bit order within the octet. The other, a 56k adaptation mode, carries only seven line bits per octet and forces the remaining bit to one.

Payload bytes arrive on a valid/ready stream. A `in_last` marker closes a frame after the flagged byte. A beat with `in_nodata` set carries no byte and closes the frame by itself, which also allows frames with no payload. Line octets leave on a valid/ready stream. The whole bit engine stalls while an octet waits to be taken.

Top module: `hdlc_tx_framer`

## Requirements
- R1: While reset is asserted and right after it, `out_valid` and `in_ready` are low.
- R2: In bearer style (`cfg_sig_idle`=0) with no frame pending, the line carries back-to-back flags that start at line bit 0 after reset, so with no reversal and no 56k mode every octet reads 0x7E.
- R3: In signalling style (`cfg_sig_idle`=1) with no frame pending, every line bit is one.
- R4: After five consecutive ones in the payload or check sequence, a zero bit is inserted and the run count restarts. This also applies when the run ends on the last check-sequence bit, before the closing flag.
- R5: Payload bytes go on the line least significant bit first. With `cfg_bit_rev`=0 and 8-bit mode, the earliest line bit of each octet sits in octet bit 0.
- R6: The check sequence is the reflected CRC-CCITT (polynomial 0x8408). It is preset to 0xFFFF at frame start and updated once per loaded byte. It is sent complemented, low byte first, least significant bit first.
- R7: The closing flag 0x7E is sent without stuffing. In signalling style the line returns to ones right after it.
- R8: A frame whose first beat has `in_nodata`=1 puts only an opening and a closing flag on the line, with no check sequence.
- R9: With `cfg_bit_rev`=1, the earliest line bit of each octet sits in octet bit 7.
- R10: With `cfg_pad56`=1, each octet carries seven line bits, and the remaining bit is one. That bit is octet bit 7 without reversal and bit 0 with reversal.
- R11: While `out_valid` is high and `out_ready` is low, `out_octet` holds its value. `in_ready` is only high when the output can advance, and it is low in any cycle that emits a line bit.
- R12: An opening flag is always sent. In bearer style a frame starts only at an idle-flag boundary, and frames sent back to back come out in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sig_idle | input | 1 | 1: idle with ones; 0: idle with flags (static) |
| cfg_bit_rev | input | 1 | 1: earliest line bit in octet bit 7 (static) |
| cfg_pad56 | input | 1 | 1: seven line bits per octet plus a one (static) |
| in_valid | input | 1 | Payload beat valid |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | This byte ends the frame |
| in_nodata | input | 1 | Beat carries no byte and ends the frame |
| in_ready | output | 1 | Payload beat accepted this cycle |
| out_valid | output | 1 | Line octet valid |
| out_octet | output | 8 | Line octet |
| out_ready | input | 1 | Line sink takes the octet |

## Verification
The bench goes after the following corner cases:
- **Stuffing across byte boundaries.** It sends runs of ones that cross byte boundaries and that end at the last check-sequence bit. A framer that resets its run count per byte, or that checks for stuffing only before the next payload bit, sends six ones and destroys the frame.
- **Closing flag and idle fill.** A framer that stuffs the closing flag, or pads it with zeros instead of ones in signalling style, fails the search for the exact expected bit string and the idle-ones check after it.
- **Empty frames.** An empty frame must show no check sequence between its two flags.
- **Octet packing options.** Both bit reversal and 56k packing are run under random backpressure. A misplaced pad bit, reversed order, or an octet that changes while stalled shows up in the unpacked stream.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPEN,
    ST_DATA,
    ST_FCS,
    ST_CLOSE
  } tx_state_e;

  // reflected CRC update over one byte, data taken LSB first
  function automatic logic [15:0] crc_byte(input logic [15:0] crc_in,
                                           input logic [7:0]  data,
                                           input logic [15:0] poly);
    logic [15:0] c;
    logic        fb;
    c = crc_in;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ data[i];
      c  = c >> 1;
      if (fb) c = c ^ poly;
    end
    return c;
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

endpackage

// File: rtl/hdlc_tx_bitgen.sv
module hdlc_tx_bitgen
  import hdlc_tx_pkg::*;
#(
  parameter logic [7:0]  FLAG      = 8'h7E,
  parameter logic [15:0] CRC_POLY  = 16'h8408,
  parameter logic [15:0] CRC_INIT  = 16'hFFFF,
  parameter int          STUFF_RUN = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_sig_idle,
  input  logic       adv,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_last,
  input  logic       in_nodata,
  output logic       in_ready,
  output logic       bit_v,
  output logic       bit_d
);
  localparam int RUN_W = $clog2(STUFF_RUN + 2);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(STUFF_RUN);

  tx_state_e        state;
  logic [3:0]       pos;
  logic [7:0]       sh;
  logic [15:0]      fcs;
  logic [15:0]      crc;
  logic [RUN_W-1:0] ones;
  logic             need, last_q, got;

  logic stuff_now, start_now, line_bit;

  assign stuff_now = (ones == RUN_MAX) &&
                     ((state == ST_DATA && !need) || state == ST_FCS || state == ST_CLOSE);
  assign start_now = in_valid && (cfg_sig_idle || pos == 4'd0);

  always_comb begin
    bit_v    = 1'b0;
    bit_d    = 1'b1;
    in_ready = 1'b0;
    line_bit = 1'b0;
    unique case (state)
      ST_IDLE: if (!start_now) begin
        bit_v = adv;
        bit_d = cfg_sig_idle ? 1'b1 : FLAG[pos[2:0]];
      end
      ST_OPEN: begin
        bit_v = adv;
        bit_d = FLAG[pos[2:0]];
      end
      ST_DATA: if (need) begin
        in_ready = adv;
      end else begin
        line_bit = sh[pos[2:0]];
        bit_v    = adv;
        bit_d    = stuff_now ? 1'b0 : line_bit;
      end
      ST_FCS: begin
        line_bit = fcs[pos];
        bit_v    = adv;
        bit_d    = stuff_now ? 1'b0 : line_bit;
      end
      ST_CLOSE: begin
        bit_v = adv;
        bit_d = stuff_now ? 1'b0 : FLAG[pos[2:0]];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      pos    <= '0;
      sh     <= '0;
      fcs    <= '0;
      crc    <= CRC_INIT;
      ones   <= '0;
      need   <= 1'b0;
      last_q <= 1'b0;
      got    <= 1'b0;
    end else if (adv) begin
      unique case (state)
        ST_IDLE: begin
          if (start_now) begin
            state <= ST_OPEN;
            pos   <= '0;
          end else if (!cfg_sig_idle) begin
            pos <= {1'b0, pos[2:0] + 3'd1};
          end
        end
        ST_OPEN: begin
          if (pos[2:0] == 3'd7) begin
            state <= ST_DATA;
            pos   <= '0;
            need  <= 1'b1;
            crc   <= CRC_INIT;
            ones  <= '0;
            got   <= 1'b0;
          end else begin
            pos <= pos + 4'd1;
          end
        end
        ST_DATA: begin
          if (need) begin
            if (in_valid) begin
              if (in_nodata) begin
                state <= got ? ST_FCS : ST_CLOSE;
                fcs   <= ~crc;
                pos   <= '0;
              end else begin
                sh     <= in_data;
                last_q <= in_last;
                crc    <= crc_byte(crc, in_data, CRC_POLY);
                need   <= 1'b0;
                pos    <= '0;
                got    <= 1'b1;
              end
            end
          end else if (stuff_now) begin
            ones <= '0;
          end else begin
            ones <= line_bit ? ones + 1'b1 : '0;
            if (pos[2:0] == 3'd7) begin
              pos <= '0;
              if (last_q) begin
                state <= ST_FCS;
                fcs   <= ~crc;
              end else begin
                need <= 1'b1;
              end
            end else begin
              pos <= pos + 4'd1;
            end
          end
        end
        ST_FCS: begin
          if (stuff_now) begin
            ones <= '0;
          end else begin
            ones <= line_bit ? ones + 1'b1 : '0;
            if (pos == 4'd15) begin
              state <= ST_CLOSE;
              pos   <= '0;
            end else begin
              pos <= pos + 4'd1;
            end
          end
        end
        ST_CLOSE: begin
          if (stuff_now) begin
            ones <= '0;
          end else if (pos[2:0] == 3'd7) begin
            state <= ST_IDLE;
            pos   <= '0;
          end else begin
            pos <= pos + 4'd1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // independent run monitor over the bits actually emitted
  logic [RUN_W-1:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (bit_v)
      run_q <= (bit_d && (state == ST_DATA || state == ST_FCS)) ? run_q + 1'b1 : '0;
  end

  assert_run_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_v && bit_d && (state == ST_DATA || state == ST_FCS)) |-> (run_q < RUN_MAX));

  assert_stuff_before_close_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_v && state == ST_CLOSE && run_q == RUN_MAX) |-> !bit_d);

  assert_crc_preset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && state == ST_OPEN && pos[2:0] == 3'd7) |=> (crc == CRC_INIT && state == ST_DATA));

  assert_no_bit_on_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !bit_v);

endmodule

// File: rtl/hdlc_tx_packer.sv
module hdlc_tx_packer
  import hdlc_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_bit_rev,
  input  logic       cfg_pad56,
  input  logic       bit_v,
  input  logic       bit_d,
  output logic       adv,
  output logic       out_valid,
  output logic [7:0] out_octet,
  input  logic       out_ready
);
  logic [2:0] cnt;
  logic [7:0] acc, word, octet_next;
  logic       oct_load;

  assign adv = !out_valid || out_ready;

  always_comb begin
    word = acc;
    word[cnt] = bit_d;
    if (cfg_pad56) word[7] = 1'b1;
    octet_next = cfg_bit_rev ? rev8(word) : word;
  end

  assign oct_load = bit_v && (cnt == (cfg_pad56 ? 3'd6 : 3'd7));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_octet <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (oct_load) begin
        cnt       <= '0;
        acc       <= '0;
        out_valid <= 1'b1;
        out_octet <= octet_next;
      end else if (bit_v) begin
        cnt <= cnt + 3'd1;
        acc <= word;
      end
    end
  end

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_octet)));

  assert_pad_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (oct_load && cfg_pad56) |=> (cfg_bit_rev ? out_octet[0] : out_octet[7]));

  assert_bit_when_room_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bit_v |-> adv);

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer #(
  parameter logic [7:0]  FLAG      = 8'h7E,
  parameter logic [15:0] CRC_POLY  = 16'h8408,
  parameter logic [15:0] CRC_INIT  = 16'hFFFF,
  parameter int          STUFF_RUN = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_sig_idle,
  input  logic       cfg_bit_rev,
  input  logic       cfg_pad56,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_last,
  input  logic       in_nodata,
  output logic       in_ready,
  output logic       out_valid,
  output logic [7:0] out_octet,
  input  logic       out_ready
);
  logic adv, bit_v, bit_d;

  hdlc_tx_bitgen #(
    .FLAG(FLAG), .CRC_POLY(CRC_POLY), .CRC_INIT(CRC_INIT), .STUFF_RUN(STUFF_RUN)
  ) u_bitgen (
    .clk(clk), .rst_n(rst_n), .cfg_sig_idle(cfg_sig_idle), .adv(adv),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_nodata(in_nodata),
    .in_ready(in_ready), .bit_v(bit_v), .bit_d(bit_d)
  );

  hdlc_tx_packer u_packer (
    .clk(clk), .rst_n(rst_n), .cfg_bit_rev(cfg_bit_rev), .cfg_pad56(cfg_pad56),
    .bit_v(bit_v), .bit_d(bit_d), .adv(adv),
    .out_valid(out_valid), .out_octet(out_octet), .out_ready(out_ready)
  );

  assert_ready_needs_room_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!out_valid || out_ready));

endmodule

// File: tb/hdlc_tx_framer_test.sv
module hdlc_tx_framer_test;
  localparam int CLK_PERIOD = 10;
  localparam int RX_MAX = 16384;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_sig_idle = 1'b0, cfg_bit_rev = 1'b0, cfg_pad56 = 1'b0;
  logic       in_valid = 1'b0, in_last = 1'b0, in_nodata = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, out_valid;
  logic [7:0] out_octet;
  logic       out_ready = 1'b1;

  hdlc_tx_framer uut (
    .clk(clk), .rst_n(rst_n), .cfg_sig_idle(cfg_sig_idle), .cfg_bit_rev(cfg_bit_rev),
    .cfg_pad56(cfg_pad56), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_nodata(in_nodata), .in_ready(in_ready), .out_valid(out_valid),
    .out_octet(out_octet), .out_ready(out_ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int   checks = 0, fails = 0;
  logic bp_en = 1'b0;
  logic [7:0] lfsr = 8'h5A;
  bit   rx_bits [RX_MAX];
  int   rx_n, pad_err, hold_err;
  logic prev_stall;
  logic [7:0] prev_oct;

  // sink: decide ready, then record the transfer at the coming edge
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = !bp_en || lfsr[0] || lfsr[1];
    if (!rst_n) begin
      rx_n = 0; pad_err = 0; hold_err = 0; prev_stall = 1'b0;
    end else begin
      if (prev_stall && out_valid && out_octet != prev_oct) hold_err++;
      prev_stall = out_valid && !out_ready;
      prev_oct   = out_octet;
      if (out_valid && out_ready) begin
        for (int k = 0; k < (cfg_pad56 ? 7 : 8); k++) begin
          if (rx_n < RX_MAX) begin
            rx_bits[rx_n] = cfg_bit_rev ? out_octet[7-k] : out_octet[k];
            rx_n++;
          end
        end
        if (cfg_pad56 && !(cfg_bit_rev ? out_octet[0] : out_octet[7])) pad_err++;
      end
    end
  end

  // expected frame bit string
  bit  exp_bits [4096];
  int  exp_n, e_ones;
  logic [7:0] pay [16];

  task automatic check(input bit ok, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
    end
  endtask

  task automatic push_raw(input bit b);
    exp_bits[exp_n] = b; exp_n++;
  endtask

  task automatic push_stuffed(input bit b);
    push_raw(b);
    if (b) begin
      e_ones++;
      if (e_ones == 5) begin push_raw(1'b0); e_ones = 0; end
    end else e_ones = 0;
  endtask

  task automatic push_flag();
    for (int k = 0; k < 8; k++) push_raw((8'h7E >> k) & 1);
  endtask

  function automatic logic [15:0] model_fcs(input int n);
    logic [15:0] r = 16'hFFFF;
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++)
        r = (r[0] ^ pay[i][k]) ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return ~r;
  endfunction

  task automatic build_frame(input int n);
    logic [15:0] f;
    exp_n = 0; e_ones = 0;
    push_flag();
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++) push_stuffed(pay[i][k]);
    if (n > 0) begin
      f = model_fcs(n);
      for (int k = 0; k < 16; k++) push_stuffed(f[k]);
    end
    push_flag();
  endtask

  function automatic int find_exp(input int from);
    for (int s = from; s + exp_n <= rx_n; s++) begin
      bit hit = 1'b1;
      for (int j = 0; j < exp_n; j++)
        if (rx_bits[s+j] != exp_bits[j]) begin hit = 1'b0; break; end
      if (hit) return s;
    end
    return -1;
  endfunction

  task automatic reset_dut(input bit sig, input bit rev, input bit pad, input bit bp);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_sig_idle = sig; cfg_bit_rev = rev; cfg_pad56 = pad; bp_en = bp;
    in_valid = 1'b0; in_last = 1'b0; in_nodata = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic beat(input logic [7:0] d, input bit last, input bit nod);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_last = last; in_nodata = nod;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    #1;
    in_valid = 1'b0; in_last = 1'b0; in_nodata = 1'b0;
  endtask

  task automatic send_frame(input int n, input bit end_nodata);
    for (int i = 0; i < n; i++) beat(pay[i], (i == n-1) && !end_nodata, 1'b0);
    if (end_nodata || n == 0) beat(8'h00, 1'b0, 1'b1);
  endtask

  function automatic int ones_after(input int p, input int len);
    int c = 0;
    for (int j = p; j < p + len && j < rx_n; j++) if (rx_bits[j]) c++;
    return c;
  endfunction

  task automatic t_reset_state();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b0, "R1 outputs low in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(out_valid == 1'b0 && in_ready == 1'b0, "R1 outputs low after reset", out_valid, 0);
  endtask

  task automatic t_bearer_idle();
    int bad = 0;
    reset_dut(1'b0, 1'b0, 1'b0, 1'b0);
    repeat (100) @(negedge clk);
    for (int j = 0; j < 64; j++) if (rx_bits[j] != ((8'h7E >> (j % 8)) & 1)) bad++;
    check(rx_n >= 64 && bad == 0, "R2 bearer idle flags", bad, 0);
  endtask

  task automatic t_bearer_frame();
    int p, p2;
    reset_dut(1'b0, 1'b0, 1'b0, 1'b0);
    repeat (20) @(negedge clk);
    pay[0] = 8'h12; pay[1] = 8'h34; pay[2] = 8'h56;
    send_frame(3, 1'b0);
    repeat (300) @(negedge clk);
    build_frame(3);
    p = find_exp(0);
    check(p >= 0, "R5 R6 LSB-first payload and FCS", p, 0);
    check(p >= 0 && p % 8 == 0, "R12 frame starts on flag boundary", p % 8, 0);
    // back-to-back frames in order
    pay[0] = 8'hC3; send_frame(1, 1'b0);
    pay[0] = 8'h3C; send_frame(1, 1'b0);
    repeat (300) @(negedge clk);
    pay[0] = 8'hC3; build_frame(1); p = find_exp(0);
    pay[0] = 8'h3C; build_frame(1); p2 = find_exp(p < 0 ? 0 : p);
    check(p >= 0 && p2 > p, "R12 back-to-back frames in order", p2, p + 1);
  endtask

  task automatic t_stuffing();
    int p;
    reset_dut(1'b0, 1'b0, 1'b0, 1'b1);
    pay[0] = 8'hFF; pay[1] = 8'hFF; pay[2] = 8'h3E; pay[3] = 8'h7E; pay[4] = 8'hF8;
    send_frame(5, 1'b0);
    repeat (600) @(negedge clk);
    build_frame(5);
    p = find_exp(0);
    check(p >= 0, "R4 R7 stuffing across bytes, unstuffed close", p, 0);
    check(hold_err == 0, "R11 octet held under backpressure", hold_err, 0);
    // frame ending in nodata beat after bytes still carries FCS
    pay[0] = 8'h01;
    send_frame(1, 1'b1);
    repeat (400) @(negedge clk);
    build_frame(1);
    p = find_exp(0);
    check(p >= 0, "R6 FCS after nodata terminator", p, 0);
  endtask

  task automatic t_sig_reversed();
    int p;
    reset_dut(1'b1, 1'b1, 1'b0, 1'b1);
    repeat (60) @(negedge clk);
    check(rx_n >= 32 && ones_after(0, 32) == 32, "R3 signalling idle ones", ones_after(0, 32), 32);
    pay[0] = 8'hA5; pay[1] = 8'h0F;
    send_frame(2, 1'b0);
    repeat (500) @(negedge clk);
    build_frame(2);
    p = find_exp(0);
    check(p >= 0, "R9 reversed octet order", p, 0);
    check(p >= 0 && ones_after(p + exp_n, 16) == 16, "R7 ones fill after close",
          ones_after(p + exp_n, 16), 16);
    check(hold_err == 0, "R11 octet held under backpressure", hold_err, 0);
  endtask

  task automatic t_empty();
    int p;
    reset_dut(1'b1, 1'b0, 1'b0, 1'b0);
    repeat (30) @(negedge clk);
    send_frame(0, 1'b1);
    repeat (200) @(negedge clk);
    build_frame(0);
    p = find_exp(0);
    check(p >= 0, "R8 empty frame is two flags", p, 0);
    check(p >= 0 && ones_after(p + exp_n, 24) == 24, "R8 no FCS after empty frame",
          ones_after(p + exp_n, 24), 24);
  endtask

  task automatic t_pad56();
    int p;
    reset_dut(1'b0, 1'b0, 1'b1, 1'b1);
    repeat (30) @(negedge clk);
    pay[0] = 8'h7E; pay[1] = 8'hFF; pay[2] = 8'h00;
    send_frame(3, 1'b0);
    repeat (600) @(negedge clk);
    build_frame(3);
    p = find_exp(0);
    check(p >= 0, "R10 seven line bits per octet", p, 0);
    check(pad_err == 0 && rx_n > 0, "R10 pad bit is one", pad_err, 0);
    reset_dut(1'b1, 1'b1, 1'b1, 1'b0);
    repeat (100) @(negedge clk);
    check(pad_err == 0 && rx_n > 0, "R10 pad bit reversed position", pad_err, 0);
  endtask

  bit done = 1'b0;

  initial begin
    t_reset_state();
    t_bearer_idle();
    t_bearer_frame();
    t_stuffing();
    t_sig_reversed();
    t_empty();
    t_pad56();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks + 1, fails + 1);
      $finish;
    end
  end

endmodule